// File: doc/BRIEF.md
# Watch Timer with Interval Interrupt

This block keeps a free-running watch counter that advances once for every slow sub-clock tick and raises a periodic interval event. One 8-bit control and status register selects which power-of-two interval produces the event. The same register latches the event in a sticky flag, gates that flag onto an interrupt line with an enable bit, and offers a command that zeroes the whole counter.

The register also shows a synchronized copy of an external oscillator-stable indication, which software can only read. It holds one plain bit whose value goes out on a pin to choose the clock source of a separate watchdog. Software writes the register through a write strobe and data bus, and reads it at all times on a read-data bus.

Register bit map, bit 7 down to bit 0: watchdog clock select, oscillator stable (read-only), interrupt enable, interval flag, counter clear, and a 3-bit interval code in bits 2 to 0.

Top module: `watch_interval_timer`

## Requirements
- R1: After reset the register reads 8'h88: the watchdog select bit (bit 7) and the clear bit (bit 3) are 1, all other bits are 0, `irq` is 0 and `wdogClkSel` is 1.
- R2: Bit 3 (counter clear) always reads back as 1, including right after a write of 0 to it.
- R3: For an interval code c from 0 to 6 in bits 2:0, the flag (bit 4) sets on the tick that moves counter bit TAP_LO+c from 0 to 1. After a counter clear, this is the 2^(TAP_LO+c)-th tick. After that the flag sets again every 2^(TAP_LO+c+1) ticks.
- R4: With code 7 the flag never sets, and the counter keeps counting.
- R5: A write with bit 3 = 0 zeroes the counter. A write with bit 3 = 1 leaves the counter untouched.
- R6: A write with bit 4 = 0 clears the flag, and a write with bit 4 = 1 leaves it unchanged. If an interval event and a clearing write fall in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when both the flag (bit 4) and the enable (bit 5) are 1.
- R8: Bit 6 shows `oscStable` after a SYNC_STAGES-flop synchronizer: it changes on the SYNC_STAGES-th clock edge after the input does. Writes to bit 6 have no effect.
- R9: Bit 7 is read/write and drives `wdogClkSel`. The value 0 selects the watch clock for the watchdog, and 1 selects the timebase clock.
- R10: The counter advances only in cycles where `subTick` is high. Idle cycles leave the interval timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| subTick | input | 1 | One-cycle pulse per sub-clock period |
| oscStable | input | 1 | Asynchronous oscillator-stable indication |
| irq | output | 1 | Interval interrupt request |
| wdogClkSel | output | 1 | Watchdog clock source select |

## Verification
The bench builds the block with TAP_LO = 2, CNT_W = 16 and SYNC_STAGES = 2, so the seven interval taps become 4 to 256 ticks from a clear instead of 512 to 32768. This makes every code, including the slowest one, reachable within a short run. Because the intervals are that short, the bench can drive each tick as an explicit pulse. It can then place a flag-clearing write in exactly the cycle of an interval event, and measure the counter phase after a clear, after idle cycles, and after a long stretch with code 7.

// File: rtl/wit_pkg.sv
`timescale 1ns/1ps
package wit_pkg;
  localparam int REG_W      = 8;
  localparam int CODE_W     = 3;
  localparam int NUM_TAPS   = 7;
  localparam int NUM_CODES  = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] CODE_OFF = 3'b111;

  // register bit positions
  localparam int BIT_CODE_LO = 0;
  localparam int BIT_CLR     = 3;
  localparam int BIT_FLAG    = 4;
  localparam int BIT_IE      = 5;
  localparam int BIT_STABLE  = 6;
  localparam int BIT_SEL     = 7;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } cntCmd_t;
endpackage

// File: rtl/wit_sync.sv
`timescale 1ns/1ps
module wit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/wit_counter.sv
`timescale 1ns/1ps
module wit_counter
  import wit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_LO = 9   // must be >= 1 and TAP_LO+NUM_TAPS <= CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCmd_t             cmd,
  output logic [NUM_TAPS-1:0] tapRise
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (cmd.clrCnt) cnt <= '0;
    else if (cmd.cntEn)  cnt <= cnt + 1'b1;
  end

  // a tap rises when the increment carries into it
  for (genvar g = 0; g < NUM_TAPS; g++) begin : tap_g
    localparam int TB = TAP_LO + g;
    assign tapRise[g] = cmd.cntEn && !cmd.clrCnt && !cnt[TB] && (&cnt[TB-1:0]);
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrCnt |=> (cnt == '0));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.cntEn && !cmd.clrCnt) |=> $stable(cnt));
  p_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.cntEn && !cmd.clrCnt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/wit_ctrl.sv
`timescale 1ns/1ps
module wit_ctrl
  import wit_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  input  logic                subTick,
  input  logic                stableSync,
  input  logic [NUM_TAPS-1:0] tapRise,
  output cntCmd_t             cmd,
  output logic [REG_W-1:0]    rdData,
  output logic                irq,
  output logic                wdogClkSel
);
  logic              selBit, ieBit, flagBit;
  logic [CODE_W-1:0] codeSel;
  logic [NUM_CODES-1:0] tapPad;
  logic              setEvt;
  logic              unusedStableWr;

  assign unusedStableWr = wrData[BIT_STABLE];

  assign cmd.clrCnt = wrEn && !wrData[BIT_CLR];
  assign cmd.cntEn  = subTick;

  // the code past the last tap selects a constant zero
  assign tapPad = {{(NUM_CODES-NUM_TAPS){1'b0}}, tapRise};
  assign setEvt = tapPad[codeSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selBit  <= 1'b1;
      ieBit   <= 1'b0;
      codeSel <= '0;
    end else if (wrEn) begin
      selBit  <= wrData[BIT_SEL];
      ieBit   <= wrData[BIT_IE];
      codeSel <= wrData[BIT_CODE_LO +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          flagBit <= 1'b0;
    else if (setEvt)                    flagBit <= 1'b1;
    else if (wrEn && !wrData[BIT_FLAG]) flagBit <= 1'b0;
  end

  assign rdData     = {selBit, stableSync, ieBit, flagBit, 1'b1, codeSel};
  assign irq        = flagBit & ieBit;
  assign wdogClkSel = selBit;

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    setEvt |=> flagBit);
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[BIT_FLAG] && !setEvt) |=> !flagBit);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (setEvt && wrEn) |=> flagBit);
  p_code_off_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (codeSel == CODE_OFF && !flagBit && !wrEn) |=> !flagBit);
  p_sel_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (wdogClkSel == $past(wrData[BIT_SEL])));
endmodule

// File: rtl/watch_interval_timer.sv
`timescale 1ns/1ps
module watch_interval_timer
  import wit_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TAP_LO      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             subTick,
  input  logic             oscStable,
  output logic             irq,
  output logic             wdogClkSel
);
  cntCmd_t             cmd;
  logic [NUM_TAPS-1:0] tapRise;
  logic                stableSync;

  wit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(oscStable), .syncOut(stableSync));

  wit_counter #(.CNT_W(CNT_W), .TAP_LO(TAP_LO)) u_counter (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tapRise(tapRise));

  wit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .subTick(subTick), .stableSync(stableSync), .tapRise(tapRise),
    .cmd(cmd), .rdData(rdData), .irq(irq), .wdogClkSel(wdogClkSel));

  p_irq_needs_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rdData[BIT_IE] && rdData[BIT_FLAG]));
  p_stable_ignores_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $stable(oscStable)) |=> (rdData[BIT_STABLE] == $past(rdData[BIT_STABLE])
                                      || rdData[BIT_STABLE] == $past(oscStable, 2)));
endmodule

// File: tb/watch_interval_timer_bench.sv
`timescale 1ns/1ps
module watch_interval_timer_bench;
  localparam int TAP_LO = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       subTick = 1'b0;
  logic       oscStable = 1'b0;
  logic       irq, wdogClkSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  watch_interval_timer #(.CNT_W(16), .TAP_LO(TAP_LO), .SYNC_STAGES(2)) u_watch_interval_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .subTick(subTick), .oscStable(oscStable), .irq(irq), .wdogClkSel(wdogClkSel));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) subTick = 1'b1;
      @(negedge clk) subTick = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk) begin wrEn = 1'b1; wrData = v; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic flagIs(input string tag, input logic exp);
    check(tag, {7'b0, rdData[4]}, {7'b0, exp});
  endtask

  task automatic testReset();
    check("R1 reset read", rdData, 8'h88);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    check("R1 reset wdogClkSel", {7'b0, wdogClkSel}, 8'h01);
  endtask

  task automatic testInterval(input logic [2:0] code);
    int k = TAP_LO + code;
    wr({5'b1000_0, code});         // clear counter and flag
    tick((1 << k) - 1);
    flagIs($sformatf("R3 code %0d before first", code), 1'b0);
    tick(1);
    flagIs($sformatf("R3 code %0d first event", code), 1'b1);
    wr({5'b1000_1, code});         // clear flag only
    tick((1 << (k + 1)) - 1);
    flagIs($sformatf("R3 code %0d before period", code), 1'b0);
    tick(1);
    flagIs($sformatf("R3 code %0d periodic", code), 1'b1);
  endtask

  task automatic testCodeOff();
    wr(8'b1000_0111);
    tick(302);
    flagIs("R4 code 7 never sets", 1'b0);
    wr(8'b1000_1000);              // code 0, no counter clear; count now 302
    tick(5);
    flagIs("R4 counter ran: no event at 5", 1'b0);
    tick(1);
    flagIs("R4 counter ran: event at 6", 1'b1);
  endtask

  task automatic testClear();
    wr(8'b1000_0000);
    tick(3);
    wr(8'b1000_0000);              // zero the counter again
    check("R2 clear bit reads 1", {7'b0, rdData[3]}, 8'h01);
    tick(3);
    flagIs("R5 cleared counter delays event", 1'b0);
    tick(1);
    flagIs("R5 event after full interval", 1'b1);
  endtask

  task automatic testIdle();
    wr(8'b1000_0000);
    tick(3);
    repeat (20) @(negedge clk);
    flagIs("R10 idle cycles do not count", 1'b0);
    tick(1);
    flagIs("R10 event on fourth tick", 1'b1);
  endtask

  task automatic testFlagWrite();
    wr(8'b1000_0000);
    tick(4);
    wr(8'b1001_1000);
    flagIs("R6 write 1 keeps flag", 1'b1);
    tick(7);                       // count 11
    @(negedge clk) begin subTick = 1'b1; wrEn = 1'b1; wrData = 8'b1000_1000; end
    @(negedge clk) begin subTick = 1'b0; wrEn = 1'b0; end
    flagIs("R6 set wins over clear", 1'b1);
    wr(8'b1000_1000);
    flagIs("R6 write 0 clears flag", 1'b0);
  endtask

  task automatic testIrq();
    wr(8'b1000_0000);
    tick(4);
    check("R7 irq low when disabled", {7'b0, irq}, 8'h00);
    wr(8'b1011_1000);
    check("R7 irq high with flag and enable", {7'b0, irq}, 8'h01);
    wr(8'b1010_1000);
    check("R7 irq low after flag clear", {7'b0, irq}, 8'h00);
    check("R7 enable reads back", {7'b0, rdData[5]}, 8'h01);
    wr(8'b1000_1000);
  endtask

  task automatic testStable();
    @(negedge clk) oscStable = 1'b1;
    @(negedge clk);
    check("R8 one edge: not yet", {7'b0, rdData[6]}, 8'h00);
    @(negedge clk);
    check("R8 two edges: visible", {7'b0, rdData[6]}, 8'h01);
    wr(8'b1000_1000);
    check("R8 write 0 ignored", {7'b0, rdData[6]}, 8'h01);
    @(negedge clk) oscStable = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'b1100_1000);
    check("R8 write 1 ignored", {7'b0, rdData[6]}, 8'h00);
  endtask

  task automatic testSel();
    wr(8'b0000_1000);
    check("R9 select 0 pin", {7'b0, wdogClkSel}, 8'h00);
    check("R9 select 0 read", {7'b0, rdData[7]}, 8'h00);
    wr(8'b1000_1000);
    check("R9 select 1 pin", {7'b0, wdogClkSel}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInterval(3'd0);
    testInterval(3'd3);
    testInterval(3'd6);
    testCodeOff();
    testClear();
    testIdle();
    testFlagWrite();
    testIrq();
    testStable();
    testSel();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule